// File: doc/BRIEF.md
# Immediate Bus-Acquisition Arbiter

This block wins ownership of a parallel SCSI bus ahead of need. Software raises an immediate-acquire request. The block then keeps arbitrating, retrying after every loss, until it wins. After a win it keeps BSY and SEL driven and parks with the bus owned. It stays there until a selection or reselection sequence elsewhere reports completion or timeout, until software releases it, or until an unexpected disconnect tears it down.

Each attempt has three steps. The block first waits for the bus to be free for a settle window. It then drives BSY and the one-hot bit of its own ID onto the data lines. At the end of an arbitration window it compares the bus against its ID, and bit 7 carries the highest priority. An abort request makes the current attempt the last one. The outcome is then either a win, which leaves the bus held until software clears the request, or a loss, which clears the request on its own.

A separate start strobe opens a REQ/ACK transfer window whose direction comes from a latched I/O bit.

Top module: `scsi_imm_arb`

## Requirements
- R1: While the acquire request is active, a lost attempt leads to a new attempt, so BSY is driven again SETTLE_CYC cycles after the loss when the bus is free, and this repeats until a win.
- R2: A win sets won_o and drives bsy_o and sel_o in the same cycle, and holds them for as long as no completion, timeout, release or disconnect arrives. A new imm_arb_set_i clears both won_o and lost_o.
- R3: In the held state, sel_done_i or sel_timeout_i clears imm_arb_o and releases bsy_o, sel_o and data_o on the next cycle.
- R4: disconnect_i clears imm_arb_o and stops all activity on the next cycle, in any state. No later attempt starts until a new set strobe arrives.
- R5: If abort_i arrives during an attempt that is then won, won_o is set and the bus stays held. imm_arb_clr_i, which is honoured only in the held state, releases BSY and SEL on the next cycle.
- R6: If abort_i arrives during an attempt that is then lost, imm_arb_o clears by itself at the decision cycle, and no further attempt starts.
- R7: A xfer_start_i strobe while idle gives a single-cycle xfer_go_o pulse and sets xfer_busy_o until xfer_done_i. xfer_send_o is 1 when io_latch_i was 0 at the strobe, and 0 otherwise.
- R8: An attempt starts only after bsy_i and sel_i have both been low for SETTLE_CYC consecutive cycles. The attempt drives bsy_o and data_o = 1 << own_id_i for ARB_CYC cycles. It wins when no data_i bit above own_id_i is set; lower bits do not matter.
- R9: A loss drops bsy_o and data_o and sets lost_o on the cycle after the decision.
- R10: An abort while waiting for a free bus clears imm_arb_o on the next cycle, with no attempt made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imm_arb_set_i | input | 1 | Start immediate acquisition (strobe) |
| imm_arb_clr_i | input | 1 | Software release of a held bus (strobe) |
| abort_i | input | 1 | Abort request (strobe) |
| own_id_i | input | 3 | Own bus ID |
| bsy_i | input | 1 | BSY driven by other devices |
| sel_i | input | 1 | SEL driven by other devices |
| data_i | input | 8 | Data lines driven by other devices |
| sel_done_i | input | 1 | Selection/reselection completed |
| sel_timeout_i | input | 1 | Selection/reselection timed out |
| disconnect_i | input | 1 | Unexpected disconnect |
| xfer_start_i | input | 1 | Start-transfer strobe |
| io_latch_i | input | 1 | Latched I/O direction bit |
| xfer_done_i | input | 1 | Transfer finished |
| imm_arb_o | output | 1 | Immediate acquire request active |
| won_o | output | 1 | Won status |
| lost_o | output | 1 | Lost status |
| bsy_o | output | 1 | BSY drive |
| sel_o | output | 1 | SEL drive |
| data_o | output | 8 | Own ID drive on data lines |
| xfer_go_o | output | 1 | Single-cycle transfer start |
| xfer_busy_o | output | 1 | Transfer window open |
| xfer_send_o | output | 1 | Transfer direction is send |

## Verification
The hardest situations to reach are the two abort outcomes. The abort has to land inside the arbitration window of a specific attempt, and the bus contents at the decision cycle then decide which clearing rule applies. The bench counts cycles from the set strobe to place abort_i one cycle into the window. It holds data_i with or without a higher bit set, and then watches for tens of cycles to confirm that no retry follows. Retry is covered by taking a higher competitor away between two attempts.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_FREE,
    ST_ARB,
    ST_HOLD
  } arb_state_e;
endpackage

// File: rtl/scsi_arb_timer.sv
module scsi_arb_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/scsi_arb_prio.sv
module scsi_arb_prio #(
  parameter int unsigned DW = 8,
  localparam int unsigned IW = $clog2(DW)
) (
  input  logic [DW-1:0] bus_i,
  input  logic [IW-1:0] id_i,
  output logic          higher_o,
  output logic [DW-1:0] id_onehot_o
);
  logic [DW-1:0] hi;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign hi[i]          = bus_i[i] && (IW'(i) > id_i);
    assign id_onehot_o[i] = (IW'(i) == id_i);
  end

  assign higher_o = |hi;
endmodule

// File: rtl/scsi_xfer_ctl.sv
module scsi_xfer_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic io_i,
  input  logic done_i,
  output logic go_o,
  output logic busy_o,
  output logic send_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_o   <= 1'b0;
      busy_o <= 1'b0;
      send_o <= 1'b0;
    end else begin
      go_o <= 1'b0;
      if (busy_o) begin
        if (done_i) busy_o <= 1'b0;
      end else if (start_i) begin
        go_o   <= 1'b1;  // start bit clears itself after one cycle
        busy_o <= 1'b1;
        send_o <= ~io_i;
      end
    end
  end
endmodule

// File: rtl/scsi_imm_arb.sv
module scsi_imm_arb #(
  parameter int unsigned DW         = 8,
  parameter int unsigned SETTLE_CYC = 2,
  parameter int unsigned ARB_CYC    = 4,
  localparam int unsigned IW        = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          imm_arb_set_i,
  input  logic          imm_arb_clr_i,
  input  logic          abort_i,
  input  logic [IW-1:0] own_id_i,
  input  logic          bsy_i,
  input  logic          sel_i,
  input  logic [DW-1:0] data_i,
  input  logic          sel_done_i,
  input  logic          sel_timeout_i,
  input  logic          disconnect_i,
  input  logic          xfer_start_i,
  input  logic          io_latch_i,
  input  logic          xfer_done_i,
  output logic          imm_arb_o,
  output logic          won_o,
  output logic          lost_o,
  output logic          bsy_o,
  output logic          sel_o,
  output logic [DW-1:0] data_o,
  output logic          xfer_go_o,
  output logic          xfer_busy_o,
  output logic          xfer_send_o
);
  import scsi_arb_pkg::*;

  arb_state_e    state_q;
  logic          abort_q, won_q, lost_q;
  logic          bus_free, settle_done, arb_done, higher;
  logic [DW-1:0] id_onehot;

  assign bus_free = !bsy_i && !sel_i;

  scsi_arb_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni,
    .en_i  (state_q == ST_WAIT_FREE && bus_free),
    .done_o(settle_done)
  );

  scsi_arb_timer #(.LIMIT(ARB_CYC)) u_arb (
    .clk_i, .rst_ni,
    .en_i  (state_q == ST_ARB),
    .done_o(arb_done)
  );

  scsi_arb_prio #(.DW(DW)) u_prio (
    .bus_i      (data_i),
    .id_i       (own_id_i),
    .higher_o   (higher),
    .id_onehot_o(id_onehot)
  );

  scsi_xfer_ctl u_xfer (
    .clk_i, .rst_ni,
    .start_i(xfer_start_i),
    .io_i   (io_latch_i),
    .done_i (xfer_done_i),
    .go_o   (xfer_go_o),
    .busy_o (xfer_busy_o),
    .send_o (xfer_send_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
      won_q   <= 1'b0;
      lost_q  <= 1'b0;
    end else if (disconnect_i) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (imm_arb_set_i) begin
          state_q <= ST_WAIT_FREE;
          won_q   <= 1'b0;
          lost_q  <= 1'b0;
          abort_q <= 1'b0;
        end
        ST_WAIT_FREE: begin
          if (abort_q || abort_i) begin
            state_q <= ST_IDLE;  // no new attempt after abort
            abort_q <= 1'b0;
          end else if (settle_done) begin
            state_q <= ST_ARB;
          end
        end
        ST_ARB: begin
          if (abort_i) abort_q <= 1'b1;
          if (arb_done) begin
            if (higher) begin
              lost_q <= 1'b1;
              if (abort_q || abort_i) begin
                state_q <= ST_IDLE;
                abort_q <= 1'b0;
              end else begin
                state_q <= ST_WAIT_FREE;
              end
            end else begin
              won_q   <= 1'b1;
              state_q <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (sel_done_i || sel_timeout_i || imm_arb_clr_i) begin
            state_q <= ST_IDLE;
            abort_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign imm_arb_o = (state_q != ST_IDLE);
  assign bsy_o     = (state_q == ST_ARB) || (state_q == ST_HOLD);
  assign sel_o     = (state_q == ST_HOLD);
  assign data_o    = bsy_o ? id_onehot : '0;
  assign won_o     = won_q;
  assign lost_o    = lost_q;
endmodule

// File: rtl/scsi_imm_arb_chk.sv
module scsi_imm_arb_chk #(
  parameter int unsigned DW = 8,
  localparam int unsigned IW = $clog2(DW)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          imm_arb_set_i,
  input logic          imm_arb_clr_i,
  input logic          abort_i,
  input logic [IW-1:0] own_id_i,
  input logic          bsy_i,
  input logic          sel_i,
  input logic [DW-1:0] data_i,
  input logic          sel_done_i,
  input logic          sel_timeout_i,
  input logic          disconnect_i,
  input logic          xfer_start_i,
  input logic          io_latch_i,
  input logic          xfer_done_i,
  input logic          imm_arb_o,
  input logic          won_o,
  input logic          lost_o,
  input logic          bsy_o,
  input logic          sel_o,
  input logic [DW-1:0] data_o,
  input logic          xfer_go_o,
  input logic          xfer_busy_o,
  input logic          xfer_send_o
);
  AST_SEL_WITH_BSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> bsy_o);  // R2
  AST_WON_HOLDS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(won_o) |-> (sel_o && bsy_o));  // R2
  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && !disconnect_i && (sel_done_i || sel_timeout_i)) |=> (!imm_arb_o && !bsy_o));  // R3
  AST_DISC_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disconnect_i |=> (!imm_arb_o && !bsy_o && !sel_o));  // R4
  AST_ID_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsy_o |-> ($onehot0(data_o) && data_o != '0));  // R8
  AST_LOSS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lost_o) |-> (!bsy_o && data_o == '0));  // R9
  AST_GO_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_go_o |=> !xfer_go_o);  // R7
endmodule

bind scsi_imm_arb scsi_imm_arb_chk #(.DW(DW)) u_chk (.*);

// File: tb/scsi_imm_arb_tb.sv
module scsi_imm_arb_tb;
  localparam int unsigned DW = 8;
  localparam int unsigned SETTLE = 2;
  localparam int unsigned ARBC = 4;
  localparam int NV = 7;
  // {data_i, own_id, expect_win}
  localparam logic [11:0] VEC [NV] = '{
    {8'h00, 3'd7, 1'b1}, {8'h80, 3'd3, 1'b0}, {8'h07, 3'd3, 1'b1},
    {8'h10, 3'd3, 1'b0}, {8'h7F, 3'd7, 1'b1}, {8'h02, 3'd0, 1'b0},
    {8'hC0, 3'd6, 1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic imm_arb_set_i = 0, imm_arb_clr_i = 0, abort_i = 0;
  logic [2:0] own_id_i = '0;
  logic bsy_i = 0, sel_i = 0;
  logic [DW-1:0] data_i = '0;
  logic sel_done_i = 0, sel_timeout_i = 0, disconnect_i = 0;
  logic xfer_start_i = 0, io_latch_i = 0, xfer_done_i = 0;
  logic imm_arb_o, won_o, lost_o, bsy_o, sel_o, xfer_go_o, xfer_busy_o, xfer_send_o;
  logic [DW-1:0] data_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  scsi_imm_arb #(.DW(DW), .SETTLE_CYC(SETTLE), .ARB_CYC(ARBC)) u_dut (.*, .clk_i(clk));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(1); s = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    tick(2); rst_ni = 1'b1; tick(1);
    chk("R2 reset imm", imm_arb_o, 0);
    chk("R2 reset bus", {bsy_o, sel_o, data_o}, 0);
    chk("R2 reset status", {won_o, lost_o, xfer_go_o, xfer_busy_o}, 0);

    // table walk: R8 priority decision, R3 timeout release, R10 abort cleanup
    for (int v = 0; v < NV; v++) begin
      logic exp_win;
      data_i = VEC[v][11:4]; own_id_i = VEC[v][3:1]; exp_win = VEC[v][0];
      pulse(imm_arb_set_i);
      tick(SETTLE - 1);
      chk("R8 settle wait", bsy_o, 0);
      tick(1);
      chk("R8 id drive", {bsy_o, data_o}, {1'b1, 8'(1 << own_id_i)});
      tick(ARBC - 1);
      chk("R8 window", {bsy_o, won_o, lost_o}, 3'b100);
      tick(1);
      chk("R8 outcome", {won_o, lost_o, sel_o, bsy_o}, {exp_win, !exp_win, exp_win, exp_win});
      if (exp_win) pulse(sel_timeout_i);
      else pulse(abort_i);
      chk("R3 R10 cleared", {imm_arb_o, bsy_o, sel_o}, 0);
      data_i = '0;
    end

    // R1 retry, R9 loss release, R2 hold, R3 done
    data_i = 8'h80; own_id_i = 3'd2;
    pulse(imm_arb_set_i);
    tick(SETTLE + ARBC);
    chk("R9 loss release", {lost_o, bsy_o, data_o}, {1'b1, 1'b0, 8'h00});
    chk("R1 still armed", imm_arb_o, 1);
    data_i = 8'h00;
    tick(SETTLE);
    chk("R1 retry drives", bsy_o, 1);
    tick(ARBC);
    chk("R1 retry won", {won_o, sel_o}, 2'b11);
    tick(50);
    chk("R2 held", {bsy_o, sel_o, imm_arb_o}, 3'b111);
    pulse(sel_done_i);
    chk("R3 done release", {imm_arb_o, bsy_o, sel_o, data_o}, 0);

    // R2 status clear on new set; R8 busy bus; R4 disconnect
    bsy_i = 1'b1;
    pulse(imm_arb_set_i);
    chk("R2 status cleared", {won_o, lost_o}, 0);
    tick(30);
    chk("R8 busy bus waits", {imm_arb_o, bsy_o}, 2'b10);
    pulse(disconnect_i);
    chk("R4 disconnect", imm_arb_o, 0);
    bsy_i = 1'b0;
    tick(20);
    chk("R4 no attempt", {imm_arb_o, bsy_o}, 0);

    // R10 abort while waiting
    bsy_i = 1'b1;
    pulse(imm_arb_set_i);
    tick(3);
    pulse(abort_i);
    chk("R10 abort wait", imm_arb_o, 0);
    bsy_i = 1'b0;
    tick(20);
    chk("R10 no attempt", bsy_o, 0);

    // R5 abort then win
    own_id_i = 3'd5;
    pulse(imm_arb_set_i);
    tick(SETTLE);
    pulse(abort_i);
    tick(ARBC - 1);
    chk("R5 won", {won_o, sel_o, bsy_o, imm_arb_o}, 4'b1111);
    tick(10);
    chk("R5 still held", {sel_o, bsy_o}, 2'b11);
    pulse(imm_arb_clr_i);
    chk("R5 release", {bsy_o, sel_o, imm_arb_o}, 0);

    // R6 abort then lose
    data_i = 8'h80;
    pulse(imm_arb_set_i);
    tick(SETTLE);
    pulse(abort_i);
    tick(ARBC - 1);
    chk("R6 self clear", {imm_arb_o, bsy_o, lost_o}, 3'b001);
    data_i = 8'h00;
    tick(20);
    chk("R6 no retry", {imm_arb_o, bsy_o}, 0);

    // R4 disconnect while held
    pulse(imm_arb_set_i);
    tick(SETTLE + ARBC);
    chk("R4 held before", sel_o, 1);
    pulse(disconnect_i);
    chk("R4 held torn down", {imm_arb_o, bsy_o, sel_o}, 0);

    // R7 transfer start
    io_latch_i = 1'b0;
    pulse(xfer_start_i);
    chk("R7 go send", {xfer_go_o, xfer_busy_o, xfer_send_o}, 3'b111);
    tick(1);
    chk("R7 self clear", {xfer_go_o, xfer_busy_o}, 2'b01);
    pulse(xfer_done_i);
    chk("R7 done", xfer_busy_o, 0);
    io_latch_i = 1'b1;
    pulse(xfer_start_i);
    chk("R7 receive", {xfer_go_o, xfer_send_o}, 2'b10);
    pulse(xfer_done_i);

    finish_run();
  end
endmodule